// File: doc/BRIEF.md
# Power-Management Status and Wake Event Block

This block keeps the 16-bit power-management status word that system software polls, along with the hardware that sets its bits. The sources are a power-button press, an active-low real-time-clock alarm, a firmware release strobe, a wake event that ends a sleep state, and a power-button hold lasting the full override time. Software reads the word through a small I/O register port. It clears a bit by writing a one to that bit's position, and writing zero leaves the bit as it was. The port also carries an 8-bit scratch location that the OS and the SMI handler use to pass values to each other.

The block sits beside the sleep sequencer. A `sleep_req` pulse marks entry into a sleep state. After that, a power-button press, or an RTC alarm while `rtc_wake_en` is high, sends a one-cycle wake request back toward the ON state. If the button stays held for `HOLD_TICKS` ticks of the slow time base, the block raises a soft-off request and an after-power-loss flag pulse, once per continuous press. There are two resets. The power-on reset clears everything. The software hard reset keeps the wake, override, RTC and button status bits.

Top module: `pm_status_wake`

## Requirements
- R1: While `por` is high, and afterwards until an event or write occurs, every status bit except bit 11 reads 0. The scratch value reads 0, and `wake_req`, `s5_req`, `afterg3_set` and `sci` are low. Bit 11's reset value is not specified.
- R2: A read with `io_rd` high and `io_addr == pm_base` returns the status word on `io_rdata` one clock later. Only bits 15 (wake), 11 (override), 10 (RTC), 8 (button) and 5 (global) are implemented. All other bits read 0 and ignore writes.
- R3: A write with `io_wr` high and `io_addr == pm_base` clears each implemented bit whose data bit is 1. `io_be[0]` gates data bits 7:0 and `io_be[1]` gates data bits 15:8. Data bits that are 0, or whose lane is not enabled, leave the status unchanged.
- R4: When a hardware set and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: A rising edge of `pwr_btn` sets bit 8 after a two-flop synchronizer. If the button is still held after bit 8 is cleared, bit 8 does not set again.
- R6: A high-to-low transition of `rtc_alarm_n` sets bit 10 after a two-flop synchronizer.
- R7: A `fw_release` pulse sets bit 5 on the next clock. `sci` is high exactly while bit 5 is set.
- R8: After a `sleep_req` pulse, a button press, or an RTC alarm while `rtc_wake_en` is high, sets bit 15 and gives a one-cycle `wake_req`. This ends the sleep state. An RTC alarm while `rtc_wake_en` is low does not wake the system. No event wakes the system unless it is asleep.
- R9: While the synchronized button stays high for `HOLD_TICKS` `tick` pulses in a row, `s5_req` and `afterg3_set` pulse for one cycle together, and bit 11 sets on the following clock. Releasing the button restarts the count. There is at most one pulse per continuous press.
- R10: `hard_rst` keeps bits 15, 11, 10 and 8. It clears bit 5, the scratch value and the sleep state.
- R11: A read at `SCRATCH_ADDR` (default 16'h00B3) returns `{8'h00, last value written with io_be[0] high}`. Scratch writes have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| hard_rst | input | 1 | Software hard reset, synchronous, active high |
| pm_base | input | AW | I/O address of the status word |
| io_addr | input | AW | Access address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_be | input | 2 | Byte-lane enables for writes |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| pwr_btn | input | 1 | Power button, high while pressed, asynchronous |
| rtc_alarm_n | input | 1 | RTC alarm, active low, asynchronous |
| fw_release | input | 1 | Firmware release strobe, synchronous |
| rtc_wake_en | input | 1 | Allows RTC alarms to wake the system |
| sleep_req | input | 1 | Pulse marking entry into a sleep state |
| tick | input | 1 | One-cycle slow time-base pulse |
| wake_req | output | 1 | One-cycle request to return to ON |
| s5_req | output | 1 | One-cycle forced soft-off request |
| afterg3_set | output | 1 | One-cycle pulse that sets the after-power-loss flag |
| sci | output | 1 | SCI, high while the global status bit is set |

## Verification
Assertions check on every cycle that set beats clear, and that a sticky bit falls only in the cycle after a write-one to it. They also check that a wake request occurs only while asleep and always leaves bit 15 set, that a soft-off pulse lasts one cycle and is followed by bit 11, and that SCI rises only after a release strobe. Other properties span longer stretches of time and are shown only by the bench's scenarios. These include the edge-versus-level behaviour of a held button, restarting the hold count on release, ignoring a disabled RTC alarm as a wake source, the split between kept and cleared bits across the hard reset, and the lane gating of clears under random writes.

// File: rtl/pm_status_pkg.sv
`timescale 1ns/1ps
package pm_status_pkg;
  localparam int STS_W = 16;
  localparam int B_WAK = 15;
  localparam int B_OVR = 11;
  localparam int B_RTC = 10;
  localparam int B_BTN = 8;
  localparam int B_GBL = 5;
  localparam logic [STS_W-1:0] STS_IMPL   = 16'h8D20;
  localparam logic [STS_W-1:0] STS_STICKY = 16'h8D00;
endpackage

// File: rtl/pm_sync.sv
`timescale 1ns/1ps
module pm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pm_hold_timer.sv
`timescale 1ns/1ps
module pm_hold_timer #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic held,
  input  logic tick,
  output logic fire
);
  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!held) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (tick && !fired_q) begin
        if (cnt_q == CW'(HOLD_TICKS - 1)) begin
          fire    <= 1'b1;
          fired_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R9
  single_fire_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R9
  fire_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(held));
endmodule

// File: rtl/pm_status_reg.sv
`timescale 1ns/1ps
module pm_status_reg import pm_status_pkg::*; (
  input  logic             clk,
  input  logic             por,
  input  logic             hard_rst,
  input  logic [STS_W-1:0] set_vec,
  input  logic [STS_W-1:0] clr_vec,
  output logic [STS_W-1:0] status
);
  logic [STS_W-1:0] nxt;

  always_comb begin
    nxt = ((status & ~clr_vec) | set_vec) & STS_IMPL;
    if (hard_rst) nxt = nxt & STS_STICKY;
  end

  always_ff @(posedge clk) begin
    if (por) status <= '0;
    else     status <= nxt;
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (por)
    !hard_rst |=> ((status & $past(set_vec & STS_IMPL)) == $past(set_vec & STS_IMPL)));

  // R10
  sticky_fall_chk: assert property (@(posedge clk) disable iff (por)
    ((($past(status) & ~status) & STS_STICKY & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/pm_status_wake.sv
`timescale 1ns/1ps
module pm_status_wake import pm_status_pkg::*; #(
  parameter int          AW           = 16,
  parameter logic [AW-1:0] SCRATCH_ADDR = 16'h00B3,
  parameter int          HOLD_TICKS   = 4,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          por,
  input  logic          hard_rst,
  input  logic [AW-1:0] pm_base,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [1:0]    io_be,
  input  logic [15:0]   io_wdata,
  output logic [15:0]   io_rdata,
  input  logic          pwr_btn,
  input  logic          rtc_alarm_n,
  input  logic          fw_release,
  input  logic          rtc_wake_en,
  input  logic          sleep_req,
  input  logic          tick,
  output logic          wake_req,
  output logic          s5_req,
  output logic          afterg3_set,
  output logic          sci
);
  logic             btn_lvl, rtc_lvl, btn_prev_q, rtc_prev_q;
  logic             btn_rise, rtc_rise, ovr_fire;
  logic             asleep_q, wake_hit;
  logic             sts_hit, scr_hit;
  logic [7:0]       scratch_q;
  logic [STS_W-1:0] set_vec, clr_vec, status_q;

  pm_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
    .clk(clk), .rst(por), .d(pwr_btn), .q(btn_lvl));
  pm_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
    .clk(clk), .rst(por), .d(~rtc_alarm_n), .q(rtc_lvl));

  always_ff @(posedge clk) begin
    if (por) begin
      btn_prev_q <= 1'b0;
      rtc_prev_q <= 1'b0;
    end else begin
      btn_prev_q <= btn_lvl;
      rtc_prev_q <= rtc_lvl;
    end
  end

  assign btn_rise = btn_lvl & ~btn_prev_q;
  assign rtc_rise = rtc_lvl & ~rtc_prev_q;

  pm_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(por), .held(btn_lvl), .tick(tick), .fire(ovr_fire));

  assign wake_hit = asleep_q & (btn_rise | (rtc_rise & rtc_wake_en));

  always_ff @(posedge clk) begin
    if (por || hard_rst) begin
      asleep_q <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= wake_hit;
      if (wake_hit)       asleep_q <= 1'b0;
      else if (sleep_req) asleep_q <= 1'b1;
    end
  end

  assign sts_hit = (io_addr == pm_base);
  assign scr_hit = (io_addr == SCRATCH_ADDR);

  always_comb begin
    set_vec        = '0;
    set_vec[B_WAK] = wake_hit;
    set_vec[B_OVR] = ovr_fire;
    set_vec[B_RTC] = rtc_rise;
    set_vec[B_BTN] = btn_rise;
    set_vec[B_GBL] = fw_release;
    clr_vec        = '0;
    if (io_wr && sts_hit) begin
      clr_vec[7:0]  = io_be[0] ? io_wdata[7:0]  : 8'h00;
      clr_vec[15:8] = io_be[1] ? io_wdata[15:8] : 8'h00;
    end
  end

  pm_status_reg u_sts (
    .clk(clk), .por(por), .hard_rst(hard_rst),
    .set_vec(set_vec), .clr_vec(clr_vec), .status(status_q));

  always_ff @(posedge clk) begin
    if (por || hard_rst)                   scratch_q <= '0;
    else if (io_wr && scr_hit && io_be[0]) scratch_q <= io_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (por) io_rdata <= '0;
    else if (io_rd) begin
      if (sts_hit)      io_rdata <= status_q;
      else if (scr_hit) io_rdata <= {8'h00, scratch_q};
      else              io_rdata <= '0;
    end
  end

  assign s5_req      = ovr_fire;
  assign afterg3_set = ovr_fire;
  assign sci         = status_q[B_GBL];

  // R8
  wake_only_asleep_chk: assert property (@(posedge clk) disable iff (por)
    wake_req |-> $past(asleep_q));

  // R8
  wake_sets_bit_chk: assert property (@(posedge clk) disable iff (por)
    wake_req |-> status_q[B_WAK]);

  // R9
  s5_then_ovr_chk: assert property (@(posedge clk) disable iff (por)
    s5_req |=> status_q[B_OVR]);

  // R7
  sci_source_chk: assert property (@(posedge clk) disable iff (por)
    $rose(sci) |-> $past(fw_release));
endmodule

// File: tb/pm_status_wake_tb.sv
`timescale 1ns/1ps
module pm_status_wake_tb;
  localparam logic [15:0] BASE = 16'h0400;
  localparam logic [15:0] SCR  = 16'h00B3;
  localparam logic [15:0] IMPL = 16'h8D20;

  logic clk = 1'b0;
  logic por = 1'b1, hard_rst = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [1:0] io_be = 2'b00;
  logic pwr_btn = 1'b0, rtc_alarm_n = 1'b1, fw_release = 1'b0;
  logic rtc_wake_en = 1'b0, sleep_req = 1'b0, tick = 1'b0;
  logic wake_req, s5_req, afterg3_set, sci;

  int vec = 0, fails = 0;
  int wake_cnt = 0, s5_cnt = 0, ag3_cnt = 0;
  logic [15:0] rd, exp_sts;
  logic [7:0] exp_scr;

  always #2 clk = ~clk;

  pm_status_wake u_dut (
    .clk(clk), .por(por), .hard_rst(hard_rst), .pm_base(BASE),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_be(io_be),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pwr_btn(pwr_btn),
    .rtc_alarm_n(rtc_alarm_n), .fw_release(fw_release),
    .rtc_wake_en(rtc_wake_en), .sleep_req(sleep_req), .tick(tick),
    .wake_req(wake_req), .s5_req(s5_req), .afterg3_set(afterg3_set), .sci(sci));

  always @(negedge clk) begin
    if (!por && wake_req)    wake_cnt++;
    if (!por && s5_req)      s5_cnt++;
    if (!por && afterg3_set) ag3_cnt++;
  end

  function automatic logic [15:0] w1c_model(logic [15:0] cur, logic [15:0] wd, logic [1:0] be);
    logic [15:0] lanes;
    lanes = {be[1] ? wd[15:8] : 8'h00, be[0] ? wd[7:0] : 8'h00};
    return cur & ~(lanes & IMPL);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [1:0] be, logic [15:0] d);
    io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_be = 2'b00;
  endtask

  task automatic rdx(logic [15:0] a, output logic [15:0] d);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic pulse_fw();  fw_release = 1'b1; @(negedge clk); fw_release = 1'b0; endtask
  task automatic pulse_sleep(); sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0; endtask
  task automatic pulse_tick(); tick = 1'b1; @(negedge clk); tick = 1'b0; idle(1); endtask
  task automatic press();   pwr_btn = 1'b1; idle(5); endtask
  task automatic release_btn(); pwr_btn = 1'b0; idle(5); endtask
  task automatic rtc_alarm(); rtc_alarm_n = 1'b0; idle(5); rtc_alarm_n = 1'b1; idle(5); endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(5);
    // R1: reset state while por held
    check("R1 wake_req", {15'd0, wake_req}, 16'd0);
    check("R1 s5_req", {15'd0, s5_req}, 16'd0);
    check("R1 sci", {15'd0, sci}, 16'd0);
    por = 1'b0;
    idle(2);
    rdx(BASE, rd);
    check("R1 status excluding bit 11", rd & 16'hF7FF, 16'h0000);
    rdx(SCR, rd);
    check("R1 scratch", rd, 16'h0000);

    // R2: reserved bits read 0 after all-ones write
    wr(BASE, 2'b11, 16'hFFFF);
    rdx(BASE, rd);
    check("R2 cleared word", rd, 16'h0000);

    // R11: scratch round trip, status untouched
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wr(SCR, 2'b01, {8'hFF, v});
      rdx(SCR, rd);
      check("R11 scratch readback", rd, {8'h00, v});
      exp_scr = v;
    end
    wr(SCR, 2'b10, 16'h00C3);
    rdx(SCR, rd);
    check("R11 scratch lane0 disabled", rd, {8'h00, exp_scr});
    rdx(BASE, rd);
    check("R11 status unaffected", rd, 16'h0000);

    // R5: button edge, not level
    press();
    rdx(BASE, rd);
    check("R5 button sets bit 8", rd, 16'h0100);
    wr(BASE, 2'b10, 16'h0100);
    idle(3);
    rdx(BASE, rd);
    check("R5 held button no re-set", rd, 16'h0000);
    release_btn();

    // R6: RTC alarm, awake -> no wake (R8)
    rtc_alarm();
    rdx(BASE, rd);
    check("R6 rtc sets bit 10", rd, 16'h0400);
    check("R8 no wake while awake", 16'(wake_cnt), 16'd0);

    // R7: firmware release and sci
    pulse_fw();
    check("R7 sci high", {15'd0, sci}, 16'd1);
    rdx(BASE, rd);
    check("R7 bit 5 set", rd, 16'h0420);

    // R3: lane gating and zero writes
    wr(BASE, 2'b01, 16'hFFFF);
    rdx(BASE, rd);
    check("R3 low lane clears bit 5 only", rd, 16'h0400);
    check("R7 sci low after clear", {15'd0, sci}, 16'd0);
    wr(BASE, 2'b11, 16'h0000);
    rdx(BASE, rd);
    check("R3 zero write no effect", rd, 16'h0400);
    wr(BASE, 2'b10, 16'h0400);
    rdx(BASE, rd);
    check("R3 high lane clears bit 10", rd, 16'h0000);

    // R4: set and clear in the same cycle
    io_addr = BASE; io_be = 2'b01; io_wdata = 16'h0020; io_wr = 1'b1; fw_release = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; fw_release = 1'b0; io_be = 2'b00;
    rdx(BASE, rd);
    check("R4 set wins", rd, 16'h0020);
    wr(BASE, 2'b11, 16'hFFFF);

    // R8: wake paths
    pulse_sleep();
    rtc_alarm();
    rdx(BASE, rd);
    check("R8 disabled rtc no wake", rd, 16'h0400);
    check("R8 disabled rtc wake count", 16'(wake_cnt), 16'd0);
    rtc_wake_en = 1'b1;
    rtc_alarm();
    rdx(BASE, rd);
    check("R8 rtc wake bit 15", rd, 16'h8400);
    check("R8 rtc wake pulse", 16'(wake_cnt), 16'd1);
    wr(BASE, 2'b11, 16'hFFFF);
    rtc_alarm();
    check("R8 no wake once awake", 16'(wake_cnt), 16'd1);
    wr(BASE, 2'b11, 16'hFFFF);
    pulse_sleep();
    press();
    release_btn();
    rdx(BASE, rd);
    check("R8 button wake", rd, 16'h8100);
    check("R8 button wake pulse", 16'(wake_cnt), 16'd2);
    wr(BASE, 2'b11, 16'hFFFF);
    rtc_wake_en = 1'b0;

    // R9: hold override
    press();
    repeat (3) pulse_tick();
    release_btn();
    press();
    repeat (3) pulse_tick();
    check("R9 release restarts count", 16'(s5_cnt), 16'd0);
    pulse_tick();
    idle(2);
    check("R9 s5 pulse", 16'(s5_cnt), 16'd1);
    check("R9 afterg3 pulse", 16'(ag3_cnt), 16'd1);
    rdx(BASE, rd);
    check("R9 bit 11 set", rd, 16'h0900);
    repeat (6) pulse_tick();
    check("R9 once per press", 16'(s5_cnt), 16'd1);
    release_btn();

    // R10: hard reset keeps sticky bits
    rtc_wake_en = 1'b1;
    pulse_sleep();
    rtc_alarm();
    pulse_fw();
    wr(SCR, 2'b01, 16'h005A);
    rdx(BASE, rd);
    check("R10 pre reset word", rd, 16'h8D20);
    pulse_sleep();
    hard_rst = 1'b1;
    @(negedge clk);
    hard_rst = 1'b0;
    rdx(BASE, rd);
    check("R10 sticky kept, bit 5 cleared", rd, 16'h8D00);
    rdx(SCR, rd);
    check("R10 scratch cleared", rd, 16'h0000);
    rtc_alarm();
    check("R10 sleep state cleared", 16'(wake_cnt), 16'd3);
    rtc_wake_en = 1'b0;

    // R3 random clears with occasional firmware sets
    exp_sts = 16'h8D00;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      logic [15:0] d;
      r = $urandom;
      d = 16'($urandom);
      if (r[0]) begin pulse_fw(); exp_sts = exp_sts | 16'h0020; end
      wr(BASE, r[2:1], d);
      exp_sts = w1c_model(exp_sts, d, r[2:1]);
      rdx(BASE, rd);
      check("R3 random clear", rd, exp_sts);
      check("R7 sci tracks bit 5", {15'd0, sci}, {15'd0, exp_sts[5]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule